// File: doc/BRIEF.md
# Two-Cycle Pulse Timer

The block produces a fixed-length high pulse on `pulse_o` each time it is started. A small controller watches `start_i` and, when started, raises the pulse and steers a datapath. The datapath is a cycle counter and an equality comparator. The comparator's match flag is fed back to the controller to end the pulse. The pulse length is therefore set by the counter and comparator, not by a chain of states. With the default `PULSE_LEN` of 2, the output stays high for exactly two clock cycles.

The controller has two states. `IDLE_S` holds the output low. `ACTIVE_S` holds it high. There are four transitions:
- **wait**: `IDLE_S` to `IDLE_S` while `start_i` is low.
- **arm**: `IDLE_S` to `ACTIVE_S` when `start_i` is high. The counter is loaded with zero.
- **dwell**: `ACTIVE_S` to `ACTIVE_S` while the comparator has not matched. The counter is loaded with its value plus one.
- **expire**: `ACTIVE_S` to `IDLE_S` when the comparator matches the last count, `PULSE_LEN-1`.

A start request that arrives while a pulse is running is not remembered. If `start_i` is still high once the controller is back in `IDLE_S`, a new pulse begins on the following cycle.

Top module: `pulse_timer`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) puts the controller in `IDLE_S` and clears the counter, so `pulse_o` is 0 after that edge.
- R2: In `IDLE_S` with `start_i` low, `pulse_o` stays 0.
- R3: A rising edge that samples `start_i` high in `IDLE_S` makes `pulse_o` 1 after that edge. On the same edge the counter is loaded with zero (load select code 0).
- R4: Once raised, `pulse_o` stays 1 for exactly `PULSE_LEN` consecutive cycles (2 by default), unless reset cuts it short.
- R5: After `PULSE_LEN` high cycles, `pulse_o` returns to 0 for at least one cycle.
- R6: `start_i` has no effect while `pulse_o` is 1. The pulse is neither lengthened nor restarted.
- R7: If `start_i` is high in the first `IDLE_S` cycle after a pulse, the next pulse begins one cycle later. Holding `start_i` high therefore gives a period of `PULSE_LEN+1` cycles.
- R8: A reset during a pulse ends it: `pulse_o` is 0 after the reset edge.
- R9: In `ACTIVE_S` the counter is loaded with its own value plus one (load select code 1). The comparator flags a match exactly when the counter equals `PULSE_LEN-1`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start request, sampled in `IDLE_S` |
| pulse_o | output | 1 | Timer output, high during `ACTIVE_S` |

## Verification
The hardest case to reach is the **expire** edge when `start_i` is already high. On that one cycle, the request must be ignored in the last `ACTIVE_S` cycle and then honoured in the next `IDLE_S` cycle, with no extra gap. The directed phase holds `start_i` high across several back-to-back pulses to reach it. The random phase keeps `start_i` high for about half the cycles, so the request keeps landing on every position of the pulse. Rare random resets land inside pulses and cover the case of a pulse cut short.

// File: rtl/pt_pkg.sv
package pt_pkg;
    typedef enum logic {
        IDLE_S   = 1'b0,
        ACTIVE_S = 1'b1
    } pt_state_e;

    typedef enum logic {
        SEL_ZERO = 1'b0,
        SEL_INC  = 1'b1
    } pt_sel_e;
endpackage

// File: rtl/pt_ctrl.sv
module pt_ctrl
    import pt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start_i,
    input  logic    match_i,
    output logic    load_o,
    output pt_sel_e sel_o,
    output logic    pulse_o
);
    pt_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= IDLE_S;
        else     state_q <= state_d;
    end

    // Next-state logic: arm / wait / dwell / expire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IDLE_S:   if (start_i) state_d = ACTIVE_S;
            ACTIVE_S: if (match_i) state_d = IDLE_S;
            default:  state_d = IDLE_S;
        endcase
    end

    // Output and datapath control logic
    always_comb begin
        load_o  = 1'b0;
        sel_o   = SEL_ZERO;
        pulse_o = 1'b0;
        unique case (state_q)
            IDLE_S: begin
                load_o = start_i;
                sel_o  = SEL_ZERO;
            end
            ACTIVE_S: begin
                load_o  = 1'b1;
                sel_o   = SEL_INC;
                pulse_o = 1'b1;
            end
            default: ;
        endcase
    end

    // R1
    property reset_idle_p;
        @(posedge clk) rst |=> (state_q == IDLE_S);
    endproperty
    reset_idle_chk: assert property (reset_idle_p);

    // R3
    property arm_p;
        @(posedge clk) disable iff (rst)
            (state_q == IDLE_S && start_i) |=> (state_q == ACTIVE_S);
    endproperty
    arm_chk: assert property (arm_p);

    // R2
    property idle_hold_p;
        @(posedge clk) disable iff (rst)
            (state_q == IDLE_S && !start_i) |=> (state_q == IDLE_S);
    endproperty
    idle_hold_chk: assert property (idle_hold_p);

    // R5
    property expire_p;
        @(posedge clk) disable iff (rst)
            (state_q == ACTIVE_S && match_i) |=> (state_q == IDLE_S);
    endproperty
    expire_chk: assert property (expire_p);

    // R6
    property dwell_p;
        @(posedge clk) disable iff (rst)
            (state_q == ACTIVE_S && !match_i) |=> (state_q == ACTIVE_S);
    endproperty
    dwell_chk: assert property (dwell_p);
endmodule

// File: rtl/pt_cnt.sv
module pt_cnt
    import pt_pkg::*;
#(
    parameter int PULSE_LEN = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    load_i,
    input  pt_sel_e sel_i,
    output logic    match_o
);
    localparam int CNT_W = (PULSE_LEN < 2) ? 1 : $clog2(PULSE_LEN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_LEN - 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Datapath multiplexer feeding the counter register
    always_comb begin
        unique case (sel_i)
            SEL_ZERO: cnt_d = '0;
            SEL_INC:  cnt_d = cnt_q + CNT_W'(1);
            default:  cnt_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (load_i) cnt_q <= cnt_d;
    end

    // Comparator
    assign match_o = (cnt_q == LAST);

    // R1
    property cnt_reset_p;
        @(posedge clk) rst |=> (cnt_q == '0);
    endproperty
    cnt_reset_chk: assert property (cnt_reset_p);

    // R3
    property cnt_zero_p;
        @(posedge clk) disable iff (rst)
            (load_i && sel_i == SEL_ZERO) |=> (cnt_q == '0);
    endproperty
    cnt_zero_chk: assert property (cnt_zero_p);

    // R9
    property cnt_inc_p;
        @(posedge clk) disable iff (rst)
            (load_i && sel_i == SEL_INC) |=> (cnt_q == $past(cnt_q) + CNT_W'(1));
    endproperty
    cnt_inc_chk: assert property (cnt_inc_p);

    // R9
    property cnt_hold_p;
        @(posedge clk) disable iff (rst)
            !load_i |=> $stable(cnt_q);
    endproperty
    cnt_hold_chk: assert property (cnt_hold_p);
endmodule

// File: rtl/pulse_timer.sv
module pulse_timer #(
    parameter int PULSE_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic pulse_o
);
    import pt_pkg::*;

    logic    load;
    logic    match;
    pt_sel_e sel;

    pt_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .match_i (match),
        .load_o  (load),
        .sel_o   (sel),
        .pulse_o (pulse_o)
    );

    pt_cnt #(.PULSE_LEN(PULSE_LEN)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load_i  (load),
        .sel_i   (sel),
        .match_o (match)
    );

    // R9
    property match_ends_p;
        @(posedge clk) disable iff (rst)
            (pulse_o && match) |=> !pulse_o;
    endproperty
    match_ends_chk: assert property (match_ends_p);

    // R8
    property reset_low_p;
        @(posedge clk) rst |=> !pulse_o;
    endproperty
    reset_low_chk: assert property (reset_low_p);
endmodule

// File: tb/test_pulse_timer.sv
`timescale 1ns/1ps
module test_pulse_timer;
    localparam int LEN = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic pulse_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model state (after the next edge)
    bit    m_on = 1'b0;
    int    m_k = 0;
    string m_tag = "R1";
    int    run = 0;
    bit    cut = 1'b0;

    always #2.5 clk = ~clk;

    pulse_timer #(.PULSE_LEN(LEN)) i_pulse_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (start_i),
        .pulse_o (pulse_o)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: pulse_o=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // expected-next computation from the requirements
    function automatic string model_tag(input bit r, input bit s, input bit on, input int k);
        if (r) return on ? "R8" : "R1";
        if (!on) return s ? "R3" : "R2";
        if (k == LEN - 1) return s ? "R7" : "R5";
        return s ? "R6" : "R4";
    endfunction

    task automatic cycle(input bit r, input bit s);
        string t;
        @(negedge clk);
        check(pulse_o, m_on, m_tag);
        if (pulse_o === 1'b1) run++;
        else begin
            if (run != 0 && !cut) begin
                checks++;
                if (run != LEN) begin
                    failures++;
                    $display("FAIL R4: pulse length=%0d expected=%0d", run, LEN);
                end
            end
            run = 0;
            cut = 1'b0;
        end
        rst = r;
        start_i = s;
        t = model_tag(r, s, m_on, m_k);
        if (r) begin
            m_on = 1'b0; m_k = 0;
            if (run != 0) cut = 1'b1;
        end else if (!m_on) begin
            if (s) begin m_on = 1'b1; m_k = 0; end
        end else if (m_k == LEN - 1) begin
            m_on = 1'b0;
        end else begin
            m_k++;
        end
        m_tag = t;
    endtask

    initial begin
        void'($urandom(32'h1bad5eed));
        // R1: reset state
        cycle(1'b1, 1'b0);
        cycle(1'b1, 1'b1);
        // R2: idle
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0);
        // R3/R4/R5: single start pulse
        cycle(1'b0, 1'b1);
        for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0);
        // R6/R7: start held across back-to-back pulses
        for (int i = 0; i < 10; i++) cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        // R6: start pulsed mid-pulse only
        cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b1);
        for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0);
        // R8: reset mid-pulse
        cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        cycle(1'b0, 1'b0);
        cycle(1'b0, 1'b0);
        // random phase
        for (int i = 0; i < 3000; i++) begin
            cycle(($urandom_range(99) < 3), ($urandom_range(99) < 50));
        end
        cycle(1'b0, 1'b0);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule